// File: doc/BRIEF.md
# Programmable Interval Down-Counter Timer

A down-counting interval timer for an embedded processor's timer unit. Software writes a start value into the count port. That value is kept as the reload value, and the count then falls by one on every cycle in which the time-base tick enable is high. When the count reaches its end, the timer sets a sticky expiry flag in a status word that it shares with other timer sources. A level interrupt follows that flag while the interrupt-enable control bit is set.

A control word sets the behaviour after expiry. With the auto-reload bit set, the timer runs periodically and starts again from the saved value. With the bit clear, it fires once and then stays at zero. Writing zero to the count stops the timer at once. Software clears the expiry flag by writing a one to its position in the status word. Reading the count port returns the remaining ticks.

Top module: `interval_timer`

## Requirements
- R1: A synchronous reset, active high, clears the count, the reload value, the expiry flag and the control bits. All read ports and `irq` are then zero.
- R2: A count write of N makes `pit_rdata` read N on the next cycle. After that the count falls by exactly one on each cycle with `tick_en` high and holds on cycles with `tick_en` low.
- R3: The tick that takes the count from 1 to its end sets bit 27 of `sts_rdata`. The bit stays set until a status write has bit 27 high. A status write with bit 27 low leaves it set.
- R4: When control bit 22 is set, an expiry loads the count from the last written value. A timer started with N therefore expires every N ticks.
- R5: When control bit 22 is clear, the count stays at zero after an expiry and further ticks cause no new expiry.
- R6: Writing zero to the count stops the timer. The count reads zero and no expiry occurs, whatever the ticks.
- R7: `irq` is high exactly when bit 27 of the status word and control bit 26 are both set. Clearing either one drops it.
- R8: A count write in the same cycle as a tick takes priority over the decrement. An expiry in the same cycle as a status clear leaves the flag set.
- R9: The shortest interval is one tick. After a count write of 1, the first tick expires the timer.
- R10: `ctl_rdata` returns only bits 22 and 26 as last written. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Time-base tick enable |
| pit_wr | input | 1 | Count/reload write strobe |
| pit_wdata | input | 32 | Start and reload value |
| pit_rdata | output | 32 | Remaining count |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word (bit 22 auto-reload, bit 26 interrupt enable) |
| ctl_rdata | output | 32 | Control word readback |
| sts_wr | input | 1 | Status write strobe (write one to clear) |
| sts_wdata | input | 32 | Status clear mask (bit 27 clears the expiry flag) |
| sts_rdata | output | 32 | Status word (bit 27 expiry flag) |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that reset is applied from the first edge and that every strobe is a clean level held for one whole cycle. The decrement and reload properties hold only in cycles without a count write, because a write takes priority. The bench drives all inputs on the falling edge, one cycle per step, so strobes never change near the sampling edge. It also places the same-cycle collisions (write with tick, expiry with clear) on purpose so that both sides of each priority rule are exercised.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int W      = 32,
  parameter int AR_BIT = 22,
  parameter int IE_BIT = 26,
  parameter int EX_BIT = 27
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         pit_wr,
  input  logic [W-1:0] pit_wdata,
  output logic [W-1:0] pit_rdata,
  input  logic         ctl_wr,
  input  logic [31:0]  ctl_wdata,
  output logic [31:0]  ctl_rdata,
  input  logic         sts_wr,
  input  logic [31:0]  sts_wdata,
  output logic [31:0]  sts_rdata,
  output logic         irq
);

  localparam logic [31:0] CTL_MASK = (32'd1 << AR_BIT) | (32'd1 << IE_BIT);
  localparam logic [31:0] STS_MASK = 32'd1 << EX_BIT;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, rld_q;
  logic [31:0]  ctl_q, sts_q;
  logic         auto_rl, int_en, expire;

  assign auto_rl = ctl_q[AR_BIT];
  assign int_en  = ctl_q[IE_BIT];
  assign expire  = tick_en && !pit_wr && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else if (pit_wr) begin
      cnt_q <= pit_wdata;
      rld_q <= pit_wdata;
    end else if (expire) begin
      cnt_q <= auto_rl ? rld_q : '0;
    end else if (tick_en && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctl_q <= '0;
    else if (ctl_wr)
      ctl_q <= ctl_wdata & CTL_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst)
      sts_q <= '0;
    else if (expire)
      sts_q <= sts_q | STS_MASK;
    else if (sts_wr)
      sts_q <= sts_q & ~(sts_wdata & STS_MASK);
  end

  assign pit_rdata = cnt_q;
  assign ctl_rdata = ctl_q;
  assign sts_rdata = sts_q;
  assign irq       = sts_q[EX_BIT] & int_en;

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick_en && !pit_wr |=> pit_rdata == $past(pit_rdata));

  assert_dec_R2: assert property (@(posedge clk) disable iff (rst)
    tick_en && !pit_wr && pit_rdata > ONE |=> pit_rdata == $past(pit_rdata) - ONE);

  assert_expire_R3: assert property (@(posedge clk) disable iff (rst)
    tick_en && !pit_wr && pit_rdata == ONE |=> sts_rdata[EX_BIT]);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    sts_rdata[EX_BIT] && !(sts_wr && sts_wdata[EX_BIT]) |=> sts_rdata[EX_BIT]);

  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    tick_en && !pit_wr && pit_rdata == ONE && ctl_rdata[AR_BIT] |=> pit_rdata == rld_q);

  assert_oneshot_R5: assert property (@(posedge clk) disable iff (rst)
    tick_en && !pit_wr && pit_rdata == ONE && !ctl_rdata[AR_BIT] |=> pit_rdata == '0);

  assert_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    pit_rdata == '0 && !pit_wr |=> pit_rdata == '0 && !$rose(sts_rdata[EX_BIT]));

  assert_mask_R7: assert property (@(posedge clk) disable iff (rst)
    !ctl_rdata[IE_BIT] |-> !irq);

  assert_write_R8: assert property (@(posedge clk) disable iff (rst)
    pit_wr |=> pit_rdata == $past(pit_wdata));

  assert_ctlbits_R10: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata & ~CTL_MASK) == '0);

endmodule

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;

  typedef struct {
    string       req;
    logic [31:0] cnt;
    logic [31:0] ctl;
    logic [31:0] sts;
    logic        irq;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0, pit_wr = 1'b0, ctl_wr = 1'b0, sts_wr = 1'b0;
  logic [31:0] pit_wdata = '0, ctl_wdata = '0, sts_wdata = '0;
  logic [31:0] pit_rdata, ctl_rdata, sts_rdata;
  logic irq;

  always #10 clk = ~clk;

  interval_timer u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .pit_wr(pit_wr), .pit_wdata(pit_wdata), .pit_rdata(pit_rdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
    .irq(irq)
  );

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_cnt = '0, m_rld = '0;
  logic m_ar = 0, m_ie = 0, m_ex = 0;

  task automatic step(string req, bit r, bit tk, bit cw, logic [31:0] cd,
                      bit kw, logic [31:0] kd, bit sw, logic [31:0] sd);
    item_t it;
    bit exp_now;
    @(negedge clk);
    rst = r; tick_en = tk; pit_wr = cw; pit_wdata = cd;
    ctl_wr = kw; ctl_wdata = kd; sts_wr = sw; sts_wdata = sd;
    if (r) begin
      m_cnt = '0; m_rld = '0; m_ar = 0; m_ie = 0; m_ex = 0;
    end else begin
      exp_now = tk && !cw && m_cnt == 32'd1;
      if (cw) begin m_cnt = cd; m_rld = cd; end
      else if (exp_now) m_cnt = m_ar ? m_rld : '0;
      else if (tk && m_cnt != 0) m_cnt = m_cnt - 1;
      if (exp_now) m_ex = 1;
      else if (sw && sd[27]) m_ex = 0;
      if (kw) begin m_ar = kd[22]; m_ie = kd[26]; end
    end
    it.req = req;
    it.cnt = m_cnt;
    it.ctl = ({31'd0, m_ar} << 22) | ({31'd0, m_ie} << 26);
    it.sts = {31'd0, m_ex} << 27;
    it.irq = m_ex & m_ie;
    q.push_back(it);
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) step(req, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic tick(string req, int n);
    for (int i = 0; i < n; i++) step(req, 0, 1, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr_cnt(string req, logic [31:0] v);
    step(req, 0, 0, 1, v, 0, 0, 0, 0);
  endtask
  task automatic wr_ctl(string req, logic [31:0] v);
    step(req, 0, 0, 0, 0, 1, v, 0, 0);
  endtask
  task automatic wr_sts(string req, logic [31:0] v);
    step(req, 0, 0, 0, 0, 0, 0, 1, v);
  endtask

  always begin
    item_t it;
    @(posedge clk);
    #5;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (pit_rdata !== it.cnt || ctl_rdata !== it.ctl ||
          sts_rdata !== it.sts || irq !== it.irq) begin
        fails++;
        $display("FAIL %s: cnt=%h ctl=%h sts=%h irq=%b expected cnt=%h ctl=%h sts=%h irq=%b",
                 it.req, pit_rdata, ctl_rdata, sts_rdata, irq,
                 it.cnt, it.ctl, it.sts, it.irq);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  localparam logic [31:0] AR = 32'h0040_0000;
  localparam logic [31:0] IE = 32'h0400_0000;
  localparam logic [31:0] EX = 32'h0800_0000;

  initial begin
    step("R1 reset", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R1 reset", 1, 1, 1, 32'h55, 1, 32'hFFFF_FFFF, 0, 0);
    step("R1 reset", 1, 0, 0, 0, 0, 0, 0, 0);
    wr_ctl("R10 ctl readback", 32'hFFFF_FFFF);
    wr_ctl("R7 enable irq oneshot", IE);
    wr_cnt("R2 load", 32'd3);
    idle("R2 hold", 2);
    tick("R2 decrement", 2);
    idle("R2 hold", 1);
    tick("R3 R7 expire", 1);
    tick("R5 oneshot stays zero", 4);
    wr_sts("R3 nonmatching clear", 32'hF7FF_FFFF);
    wr_sts("R3 R7 clear drops irq", EX);
    wr_ctl("R4 autoreload", AR | IE);
    wr_cnt("R4 load", 32'd2);
    tick("R4 periodic", 5);
    wr_sts("R7 clear", EX);
    step("R8 write beats tick", 0, 1, 1, 32'd4, 0, 0, 0, 0);
    tick("R8 run", 3);
    step("R8 expire beats clear", 0, 1, 0, 0, 0, 0, 1, EX);
    wr_sts("R3 clear", EX);
    wr_ctl("R9 oneshot", IE);
    wr_cnt("R9 load one", 32'd1);
    tick("R9 first tick expires", 1);
    wr_sts("R3 clear", EX);
    wr_ctl("R6 autoreload", AR | IE);
    wr_cnt("R6 load", 32'd5);
    tick("R6 run", 2);
    wr_cnt("R6 stop", 32'd0);
    tick("R6 no expiry", 8);
    wr_ctl("R7 irq masked", AR);
    wr_cnt("R7 load", 32'd2);
    tick("R7 expire masked", 2);
    wr_ctl("R7 unmask", AR | IE);
    wr_ctl("R7 mask again", AR);
    wr_cnt("R2 large", 32'hFFFF_FFFF);
    tick("R2 large dec", 3);
    step("R1 midstream reset", 1, 1, 0, 0, 0, 0, 0, 0);
    idle("R1 after reset", 2);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule